// File: doc/BRIEF.md
# Branch and Loop Condition Evaluator

This block decides whether a conditional jump or a counted loop instruction redirects the program, and it computes the resulting instruction pointer and count value. One request is presented per cycle. The request names an operation class, a 4-bit condition selector, the five status flags (carry, zero, sign, overflow, parity), the 16-bit count register, the current instruction pointer and an 8-bit signed displacement.

For the conditional-jump class, the selector picks one of eight base tests, and selector bit 0 inverts that test. The count-zero jump tests the count without changing it. The three loop classes first decrement the count and then test the new value, and two of them also test the zero flag. When the branch is taken, the new pointer is the current pointer plus the sign-extended displacement, modulo 2^16. Otherwise the new pointer is the current pointer. All three results are registered and appear together one cycle after the request.

Top module: `brcond_eval`

## Requirements
- R1: Conditional class (`op_class`=0) with selector base (`cond_sel[3:1]`) 0, 2, 4 or 5 tests a single flag. Base 0 tests OF=1, base 2 tests ZF=1, base 4 tests SF=1 and base 5 tests PF=1.
- R2: Conditional class, unsigned base tests. Base 1 tests CF=1 (below). Base 3 tests (CF OR ZF)=1 (below or equal).
- R3: Conditional class, signed base tests. Base 6 tests (SF XOR OF)=1 (less). Base 7 tests ((SF XOR OF) OR ZF)=1 (less or equal).
- R4: `cond_sel[0]`=1 inverts the base test. Odd selectors are therefore not-overflow, not-below, not-equal, above, not-sign, parity-odd, greater-or-equal and greater.
- R5: Count-zero class (`op_class`=1) is taken exactly when `cnt_in` is 0. `cnt_out` equals `cnt_in`. The conditional class also leaves the count unchanged.
- R6: Loop class (`op_class`=2) outputs `cnt_in`-1 modulo 2^16 as `cnt_out`. It is taken when that new count is nonzero, so a count of 0 wraps to 0xFFFF and is taken.
- R7: Loop-while-zero (`op_class`=3) is taken when the decremented count is nonzero and ZF=1. Loop-while-not-zero (`op_class`=4) is taken when the decremented count is nonzero and ZF=0. Both decrement the count as in R6.
- R8: When taken, `next_ip` = `ip_in` + sign-extended `disp`, modulo 2^16. When not taken, `next_ip` = `ip_in`.
- R9: Results appear on the clock edge that samples `req_valid`=1, and `res_valid` is high for that one cycle. When `req_valid`=0, `res_valid` drops and `taken`, `next_ip` and `cnt_out` keep their values.
- R10: While `rst_n`=0, all outputs are 0.
- R11: Reserved classes 5 to 7 are never taken, leave `cnt_out`=`cnt_in` and give `next_ip`=`ip_in`, whatever the flags and selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| op_class | input | 3 | 0 cond, 1 count-zero, 2 loop, 3 loop-while-zero, 4 loop-while-not-zero |
| cond_sel | input | 4 | Condition selector, bit 0 inverts |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| cnt_in | input | 16 | Current count register |
| ip_in | input | 16 | Current instruction pointer |
| disp | input | 8 | Signed displacement |
| res_valid | output | 1 | Results below are fresh |
| taken | output | 1 | Branch taken |
| next_ip | output | 16 | Resulting instruction pointer |
| cnt_out | output | 16 | Resulting count |

## Verification
Every result has one cycle of latency. The rising edge that samples a request loads `taken`, `next_ip`, `cnt_out` and `res_valid` together. The bench drives each request on a falling edge, drops `req_valid` on the next falling edge, and reads all outputs at that moment, which is half a cycle after the loading edge. For the hold behaviour, the bench waits one more falling edge with no request and confirms that `res_valid` has dropped and that the three results still match the previous values.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

  typedef enum logic [2:0] {
    OPC_COND   = 3'd0,
    OPC_CNTZ   = 3'd1,
    OPC_LOOP   = 3'd2,
    OPC_LOOPZ  = 3'd3,
    OPC_LOOPNZ = 3'd4
  } brc_op_e;

  typedef enum logic [2:0] {
    BASE_OVF   = 3'd0,
    BASE_CARRY = 3'd1,
    BASE_ZERO  = 3'd2,
    BASE_CZ    = 3'd3,
    BASE_SIGN  = 3'd4,
    BASE_PAR   = 3'd5,
    BASE_LT    = 3'd6,
    BASE_LE    = 3'd7
  } brc_base_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
  } brc_flags_t;

  // Positive form of each base test, before the inversion bit.
  function automatic logic brc_base_hit(input logic [2:0] base, input brc_flags_t f);
    logic hit;
    case (brc_base_e'(base))
      BASE_OVF:   hit = f.of;
      BASE_CARRY: hit = f.cf;
      BASE_ZERO:  hit = f.zf;
      BASE_CZ:    hit = f.cf | f.zf;
      BASE_SIGN:  hit = f.sf;
      BASE_PAR:   hit = f.pf;
      BASE_LT:    hit = f.sf ^ f.of;
      default:    hit = (f.sf ^ f.of) | f.zf;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/brcond_flagtest.sv
module brcond_flagtest
  import brcond_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel,
  input  brc_flags_t       flags,
  output logic             cond_met
);
  localparam int BASE_W = SEL_W - 1;

  logic [BASE_W-1:0] base;
  logic              base_hit;

  assign base     = sel[SEL_W-1:1];
  assign base_hit = brc_base_hit(base, flags);
  assign cond_met = base_hit ^ sel[0];
endmodule

// File: rtl/brcond_countctl.sv
module brcond_countctl
  import brcond_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [2:0]       op_class,
  input  logic             cond_met,
  input  logic             zf,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             go,
  output logic [CNT_W-1:0] cnt_next,
  output logic             cnt_in_zero,
  output logic             dec_nonzero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_dec;

  assign cnt_dec     = cnt_in - ONE;
  assign cnt_in_zero = (cnt_in == '0);
  assign dec_nonzero = (cnt_dec != '0);

  always_comb begin
    go       = 1'b0;
    cnt_next = cnt_in;
    case (op_class)
      OPC_COND:   go = cond_met;
      OPC_CNTZ:   go = cnt_in_zero;
      OPC_LOOP:   begin cnt_next = cnt_dec; go = dec_nonzero;        end
      OPC_LOOPZ:  begin cnt_next = cnt_dec; go = dec_nonzero & zf;   end
      OPC_LOOPNZ: begin cnt_next = cnt_dec; go = dec_nonzero & ~zf;  end
      default:    go = 1'b0;
    endcase
  end
endmodule

// File: rtl/brcond_target.sv
module brcond_target #(
  parameter int IP_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [IP_W-1:0]   ip_cur,
  input  logic [DISP_W-1:0] disp,
  input  logic              go,
  output logic [IP_W-1:0]   ip_new
);
  localparam int EXT_W = IP_W - DISP_W;

  function automatic logic [IP_W-1:0] rel_target(input logic [IP_W-1:0] ip,
                                                 input logic [DISP_W-1:0] d);
    return ip + {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  assign ip_new = go ? rel_target(ip_cur, disp) : ip_cur;
endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
  import brcond_pkg::*;
#(
  parameter int IP_W   = 16,
  parameter int CNT_W  = 16,
  parameter int DISP_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        op_class,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic              flag_cf,
  input  logic              flag_zf,
  input  logic              flag_sf,
  input  logic              flag_of,
  input  logic              flag_pf,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [IP_W-1:0]   ip_in,
  input  logic [DISP_W-1:0] disp,
  output logic              res_valid,
  output logic              taken,
  output logic [IP_W-1:0]   next_ip,
  output logic [CNT_W-1:0]  cnt_out
);
  brc_flags_t       flags;
  logic             cond_met;
  logic             go;
  logic [CNT_W-1:0] cnt_next;
  logic [IP_W-1:0]  ip_new;
  logic             cnt_in_zero;
  logic             dec_nonzero;
  logic             is_loop_class;
  logic             is_reserved;

  assign flags         = '{cf: flag_cf, zf: flag_zf, sf: flag_sf, of: flag_of, pf: flag_pf};
  assign is_loop_class = (op_class == OPC_LOOP) || (op_class == OPC_LOOPZ) ||
                         (op_class == OPC_LOOPNZ);
  assign is_reserved   = (op_class > OPC_LOOPNZ);

  brcond_flagtest #(.SEL_W(SEL_W)) u_flagtest (
    .sel      (cond_sel),
    .flags    (flags),
    .cond_met (cond_met)
  );

  brcond_countctl #(.CNT_W(CNT_W)) u_countctl (
    .op_class    (op_class),
    .cond_met    (cond_met),
    .zf          (flag_zf),
    .cnt_in      (cnt_in),
    .go          (go),
    .cnt_next    (cnt_next),
    .cnt_in_zero (cnt_in_zero),
    .dec_nonzero (dec_nonzero)
  );

  brcond_target #(.IP_W(IP_W), .DISP_W(DISP_W)) u_target (
    .ip_cur (ip_in),
    .disp   (disp),
    .go     (go),
    .ip_new (ip_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      taken     <= 1'b0;
      next_ip   <= '0;
      cnt_out   <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        taken   <= go;
        next_ip <= ip_new;
        cnt_out <= cnt_next;
      end
    end
  end

  // Assertions
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(taken) && $stable(next_ip) && $stable(cnt_out)));
  assert_cntz_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_class == OPC_CNTZ) |=> (cnt_out == $past(cnt_in)));
  assert_cntz_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_class == OPC_CNTZ) |=> (taken == $past(cnt_in_zero)));
  assert_loop_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_loop_class) |=> (cnt_out == $past(cnt_in) - CNT_W'(1)));
  assert_loop_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_loop_class && !dec_nonzero) |=> !taken);
  assert_nottaken_ip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (taken || next_ip == $past(ip_in)));
  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_reserved) |=> (!taken && cnt_out == $past(cnt_in)));
endmodule

// File: tb/test_brcond_eval.sv
module test_brcond_eval;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  cls;
    logic [3:0]  sel;
    logic [4:0]  fl;    // {cf, zf, sf, of, pf}
    logic [15:0] cnt;
    logic [15:0] ip;
    logic [7:0]  dsp;
    logic        tk;
    logic [15:0] nip;
    logic [15:0] ncnt;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 4'd4,  5'b01000, 16'h0005, 16'h1000, 8'h10, 1'b1, 16'h1010, 16'h0005}, // R1 equal
    '{3'd0, 4'd4,  5'b00000, 16'h0005, 16'h1000, 8'h10, 1'b0, 16'h1000, 16'h0005}, // R1
    '{3'd0, 4'd15, 5'b00110, 16'h0009, 16'h1000, 8'hF0, 1'b1, 16'h0FF0, 16'h0009}, // R3 R4 greater
    '{3'd0, 4'd12, 5'b00100, 16'h0009, 16'hFFF8, 8'h08, 1'b1, 16'h0000, 16'h0009}, // R3 R8 wrap
    '{3'd0, 4'd7,  5'b00000, 16'h0009, 16'h0000, 8'h80, 1'b1, 16'hFF80, 16'h0009}, // R2 R4 above
    '{3'd1, 4'd0,  5'b00000, 16'h0000, 16'h2000, 8'h04, 1'b1, 16'h2004, 16'h0000}, // R5
    '{3'd1, 4'd0,  5'b11111, 16'h0001, 16'h2000, 8'h04, 1'b0, 16'h2000, 16'h0001}, // R5
    '{3'd2, 4'd0,  5'b00000, 16'h0001, 16'h3000, 8'h02, 1'b0, 16'h3000, 16'h0000}, // R6
    '{3'd2, 4'd0,  5'b00000, 16'h0000, 16'h3000, 8'hFE, 1'b1, 16'h2FFE, 16'hFFFF}, // R6 wrap
    '{3'd2, 4'd0,  5'b01000, 16'h0005, 16'h3000, 8'h02, 1'b1, 16'h3002, 16'h0004}, // R6
    '{3'd3, 4'd0,  5'b01000, 16'h0005, 16'h4000, 8'h7F, 1'b1, 16'h407F, 16'h0004}, // R7
    '{3'd3, 4'd0,  5'b00000, 16'h0005, 16'h4000, 8'h7F, 1'b0, 16'h4000, 16'h0004}, // R7
    '{3'd4, 4'd0,  5'b00000, 16'h0005, 16'h4000, 8'h7F, 1'b1, 16'h407F, 16'h0004}, // R7
    '{3'd4, 4'd0,  5'b01000, 16'h0005, 16'h4000, 8'h7F, 1'b0, 16'h4000, 16'h0004}, // R7
    '{3'd3, 4'd0,  5'b01000, 16'h0001, 16'h4000, 8'h7F, 1'b0, 16'h4000, 16'h0000}, // R7 count ends
    '{3'd6, 4'd0,  5'b00010, 16'h0007, 16'h5000, 8'h33, 1'b0, 16'h5000, 16'h0007}  // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  op_class = '0;
  logic [3:0]  cond_sel = '0;
  logic        flag_cf = 1'b0, flag_zf = 1'b0, flag_sf = 1'b0, flag_of = 1'b0, flag_pf = 1'b0;
  logic [15:0] cnt_in = '0;
  logic [15:0] ip_in = '0;
  logic [7:0]  disp = '0;
  logic        res_valid, taken;
  logic [15:0] next_ip, cnt_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brcond_eval i_brcond_eval (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_class(op_class),
    .cond_sel(cond_sel), .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_sf(flag_sf),
    .flag_of(flag_of), .flag_pf(flag_pf), .cnt_in(cnt_in), .ip_in(ip_in),
    .disp(disp), .res_valid(res_valid), .taken(taken), .next_ip(next_ip),
    .cnt_out(cnt_out)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Independent restatement of the condition table.
  function automatic bit ref_cond(input int sel, input logic [4:0] fl);
    bit cf, zf, sf, of, pf, pos;
    {cf, zf, sf, of, pf} = fl;
    case (sel / 2)
      0: pos = (of == 1'b1);
      1: pos = (cf == 1'b1);
      2: pos = (zf == 1'b1);
      3: pos = (cf == 1'b1) || (zf == 1'b1);
      4: pos = (sf == 1'b1);
      5: pos = (pf == 1'b1);
      6: pos = (sf != of);
      default: pos = (sf != of) || (zf == 1'b1);
    endcase
    if (sel % 2 == 1) return !pos;
    return pos;
  endfunction

  function automatic string sel_tag(input int sel);
    case (sel / 2)
      1, 3:    return "R2/R4";
      6, 7:    return "R3/R4";
      default: return "R1/R4";
    endcase
  endfunction

  task automatic apply(input logic [2:0] c, input logic [3:0] s, input logic [4:0] f,
                       input logic [15:0] n, input logic [15:0] p, input logic [7:0] d);
    @(negedge clk);
    op_class = c; cond_sel = s;
    {flag_cf, flag_zf, flag_sf, flag_of, flag_pf} = f;
    cnt_in = n; ip_in = p; disp = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [33:0] held;
    // R10: reset state
    repeat (3) @(negedge clk);
    check({res_valid, taken, next_ip, cnt_out} == '0, "R10", "outputs in reset",
          {2'b0, res_valid, taken, next_ip, cnt_out}, 36'h0);
    rst_n = 1'b1;

    // Directed table
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].cls, VECS[i].sel, VECS[i].fl, VECS[i].cnt, VECS[i].ip, VECS[i].dsp);
      check(taken == VECS[i].tk, "R5/R6/R7/R11", $sformatf("vec %0d taken", i),
            36'(taken), 36'(VECS[i].tk));
      check(next_ip == VECS[i].nip, "R8", $sformatf("vec %0d next_ip", i),
            36'(next_ip), 36'(VECS[i].nip));
      check(cnt_out == VECS[i].ncnt, "R5/R6", $sformatf("vec %0d cnt_out", i),
            36'(cnt_out), 36'(VECS[i].ncnt));
    end

    // R9: one-cycle valid pulse and hold while idle
    apply(3'd0, 4'd2, 5'b10000, 16'h00AA, 16'h6000, 8'h20);
    check(res_valid == 1'b1, "R9", "valid after request", 36'(res_valid), 36'h1);
    held = {taken, next_ip, cnt_out};
    @(negedge clk);
    check(res_valid == 1'b0, "R9", "valid drops", 36'(res_valid), 36'h0);
    check({taken, next_ip, cnt_out} == held, "R9", "hold while idle",
          36'({taken, next_ip, cnt_out}), 36'(held));
    check(held == {1'b1, 16'h6020, 16'h00AA}, "R2", "below taken",
          36'(held), 36'({1'b1, 16'h6020, 16'h00AA}));

    // R11: all reserved classes with a flag set that would satisfy selector 0
    for (int c = 5; c < 8; c++) begin
      apply(3'(c), 4'd0, 5'b11111, 16'h0000, 16'h7000, 8'h44);
      check(!taken && next_ip == 16'h7000 && cnt_out == 16'h0000, "R11",
            $sformatf("class %0d", c), 36'({taken, next_ip, cnt_out}),
            36'({1'b0, 16'h7000, 16'h0000}));
    end

    // R1 R2 R3 R4: full sweep of selectors against all flag patterns
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 32; f++) begin
        bit exp_tk;
        logic [15:0] exp_ip;
        exp_tk = ref_cond(s, 5'(f));
        exp_ip = exp_tk ? 16'h8011 : 16'h8000;
        apply(3'd0, 4'(s), 5'(f), 16'h0033, 16'h8000, 8'h11);
        check(taken == exp_tk && next_ip == exp_ip && cnt_out == 16'h0033, sel_tag(s),
              $sformatf("sel %0d flags %b", s, 5'(f)),
              36'({taken, next_ip, cnt_out}), 36'({exp_tk, exp_ip, 16'h0033}));
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule